// File: doc/BRIEF.md
# Dual-Bank Shared Memory Slave with Arbitrated Processor Port

This block holds two 32-bit synchronous RAM banks and gives two clients access to them. A 32-bit processor uses a pipelined memory-mapped slave port and touches one bank per transfer. A 64-bit processing element uses a second port that touches both banks in the same cycle, one bank per 32-bit half. The processing element always occupies both banks, so any cycle in which both ports request is a conflict. A small arbiter state machine settles each conflict.

The processing-element port wins a conflict unless the processor has already been held off for `MAX_WAIT` consecutive cycles. In that case the processor is forced through and the processing element waits one cycle. A port that is refused raises its wait-request. It must hold its command stable until the first cycle in which wait-request is low, and the command is accepted at that clock edge. Read data comes back on each port with a valid strobe. A shift register of length `RD_LAT` carries the strobe, so it always matches the RAM's read latency.

The arbiter has three states:
- ARB_FREE: no processor denial is pending.
- ARB_WAIT: the processor has been denied at least once but fewer than `MAX_WAIT` times.
- ARB_FORCE: the processor is granted and the other port is held.

Its transitions are:
- FREE to WAIT, or straight to FORCE when `MAX_WAIT` is 1, on a first denial.
- WAIT to WAIT on a further denial below the limit.
- WAIT to FORCE when a denial reaches the limit.
- WAIT to FREE when the processor is granted or withdraws.
- FORCE to FREE always.

Top module: `dualbank_mem`

## Requirements
- R1: While reset is asserted and in the cycle after it, both read-valid outputs are low, and with idle inputs both wait-request outputs are low.
- R2: A processor word address selects a bank with its bit 0 (0 is the low bank, 1 is the high bank) and a row with its upper bits. A 64-bit word at row i holds the low bank's row i in bits 31:0 and the high bank's row i in bits 63:32, so it is the processor words 2i and 2i+1.
- R3: When both ports request and the processor has been refused fewer than `MAX_WAIT` consecutive cycles, the 64-bit port is accepted and the processor sees wait-request high. The two ports are never accepted in the same cycle.
- R4: Processor wait-request is never high for more than `MAX_WAIT` consecutive cycles. In the cycle after `MAX_WAIT` refusals the processor is accepted, and a 64-bit request in that cycle sees its own wait-request high.
- R5: Processor wait-request is low whenever the processor issues no command, and whenever the 64-bit port issues none.
- R6: Each accepted processor read produces exactly one read-valid pulse. The pulse is sampled at the `RD_LAT`-th rising edge after the edge that accepted the read. No pulse occurs without a read.
- R7: Processor read data in the valid cycle equals the addressed word as left by all writes accepted before the read.
- R8: A processor write changes only the bytes whose enable bit is set; bit k of the 4-bit enable covers data bits 8k+7..8k.
- R9: A 64-bit write takes an 8-bit enable. Bits 3:0 cover the low bank's bytes, bits 7:4 cover the high bank's bytes, and disabled bytes are unchanged.
- R10: Each accepted 64-bit read produces one read-valid pulse `RD_LAT` edges after acceptance. Its data then equals the combined row.
- R11: A processor command held under wait-request takes effect exactly once, at the first edge where wait-request is low. A read-increment-write loop therefore advances the stored value by exactly one per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | BANK_AW+1 | Processor word address; bit 0 picks the bank |
| cpu_read | input | 1 | Processor read command |
| cpu_write | input | 1 | Processor write command |
| cpu_wdata | input | 32 | Processor write data |
| cpu_be | input | 4 | Processor byte enables |
| cpu_waitreq | output | 1 | Processor command not accepted this cycle |
| cpu_rdata | output | 32 | Processor read data |
| cpu_rvalid | output | 1 | Qualifies cpu_rdata |
| pe_addr | input | BANK_AW | 64-bit port row address |
| pe_read | input | 1 | 64-bit read command |
| pe_write | input | 1 | 64-bit write command |
| pe_wdata | input | 64 | 64-bit write data |
| pe_be | input | 8 | 64-bit byte enables, 4 per bank |
| pe_waitreq | output | 1 | 64-bit command not accepted this cycle |
| pe_rdata | output | 64 | 64-bit read data |
| pe_rvalid | output | 1 | Qualifies pe_rdata |

## Verification
The bench builds the block with `RD_LAT` = 2, `MAX_WAIT` = 3 and `BANK_AW` = 4. A two-cycle RAM is the case where a one-stage valid pipe would put data and strobe one clock apart, so a latency of 2 exposes any misalignment. A short wait limit lets an unbroken stream of 64-bit requests drive the arbiter through FREE, WAIT and FORCE within a few cycles. The small banks let the bench clear every row and keep a full reference model, so each read in the read-increment-write loop can be checked under random 64-bit traffic.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_N = WORD_W / 8;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_WAIT  = 2'd1,
        ARB_FORCE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dbm_bank.sv
module dbm_bank
    import dbm_pkg::*;
#(
    parameter int AW     = 12,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANE_N-1:0] be,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem  [DEPTH];
    logic [WORD_W-1:0] pipe [RD_LAT];

    // Byte-lane write, array read into the first pipe stage, then delay stages.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANE_N; i++) begin
                if (be[i]) begin
                    mem[addr][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
        if (rd_en) begin
            pipe[0] <= mem[addr];
        end
        for (int k = RD_LAT - 1; k > 0; k--) begin
            pipe[k] <= pipe[k-1];
        end
    end

    assign rdata = pipe[RD_LAT-1];

endmodule

// File: rtl/dbm_arbiter.sv
module dbm_arbiter
    import dbm_pkg::*;
#(
    parameter int MAX_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic pe_req,
    output logic cpu_gnt,
    output logic pe_gnt
);

    localparam int CW = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

    arb_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          denied;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: grants
    always_comb begin
        cpu_gnt = 1'b0;
        pe_gnt  = 1'b0;
        unique case (state_q)
            ARB_FORCE: begin
                cpu_gnt = cpu_req;
                pe_gnt  = pe_req && !cpu_req;
            end
            ARB_FREE, ARB_WAIT: begin
                pe_gnt  = pe_req;
                cpu_gnt = cpu_req && !pe_req;
            end
            default: begin
                cpu_gnt = 1'b0;
                pe_gnt  = 1'b0;
            end
        endcase
    end

    assign denied = cpu_req && !cpu_gnt;

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARB_FREE: begin
                if (denied) begin
                    cnt_d   = CW'(1);
                    state_d = (LIMIT == CW'(1)) ? ARB_FORCE : ARB_WAIT;
                end
            end
            ARB_WAIT: begin
                if (!denied) begin
                    state_d = ARB_FREE;
                    cnt_d   = '0;
                end else if (cnt_q + CW'(1) >= LIMIT) begin
                    state_d = ARB_FORCE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ARB_FORCE: begin
                state_d = ARB_FREE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ARB_FREE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/dbm_rd_align.sv
module dbm_rd_align #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rd_acc,
    input  logic cpu_bank,
    input  logic pe_rd_acc,
    output logic cpu_valid,
    output logic cpu_bank_out,
    output logic pe_valid
);

    logic [RD_LAT-1:0] cv_q, cb_q, pv_q;

    generate
        if (RD_LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cv_q <= '0;
                    cb_q <= '0;
                    pv_q <= '0;
                end else begin
                    cv_q <= cpu_rd_acc;
                    cb_q <= cpu_bank;
                    pv_q <= pe_rd_acc;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cv_q <= '0;
                    cb_q <= '0;
                    pv_q <= '0;
                end else begin
                    cv_q <= {cv_q[RD_LAT-2:0], cpu_rd_acc};
                    cb_q <= {cb_q[RD_LAT-2:0], cpu_bank};
                    pv_q <= {pv_q[RD_LAT-2:0], pe_rd_acc};
                end
            end
        end
    endgenerate

    assign cpu_valid    = cv_q[RD_LAT-1];
    assign cpu_bank_out = cb_q[RD_LAT-1];
    assign pe_valid     = pv_q[RD_LAT-1];

endmodule

// File: rtl/dualbank_mem.sv
module dualbank_mem
    import dbm_pkg::*;
#(
    parameter int BANK_AW  = 12,
    parameter int RD_LAT   = 1,
    parameter int MAX_WAIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_AW:0]     cpu_addr,
    input  logic                 cpu_read,
    input  logic                 cpu_write,
    input  logic [WORD_W-1:0]    cpu_wdata,
    input  logic [LANE_N-1:0]    cpu_be,
    output logic                 cpu_waitreq,
    output logic [WORD_W-1:0]    cpu_rdata,
    output logic                 cpu_rvalid,
    input  logic [BANK_AW-1:0]   pe_addr,
    input  logic                 pe_read,
    input  logic                 pe_write,
    input  logic [2*WORD_W-1:0]  pe_wdata,
    input  logic [2*LANE_N-1:0]  pe_be,
    output logic                 pe_waitreq,
    output logic [2*WORD_W-1:0]  pe_rdata,
    output logic                 pe_rvalid
);

    localparam int NBANK = 2;

    logic               cpu_req, pe_req, cpu_gnt, pe_gnt;
    logic               cpu_bank, rsel;
    logic [BANK_AW-1:0] cpu_row;

    logic [NBANK-1:0]   bk_wr, bk_rd;
    logic [BANK_AW-1:0] bk_addr [NBANK];
    logic [WORD_W-1:0]  bk_wd   [NBANK];
    logic [WORD_W-1:0]  bk_q    [NBANK];
    logic [LANE_N-1:0]  bk_be   [NBANK];

    assign cpu_req  = cpu_read || cpu_write;
    assign pe_req   = pe_read || pe_write;
    assign cpu_bank = cpu_addr[0];
    assign cpu_row  = cpu_addr[BANK_AW:1];

    dbm_arbiter #(.MAX_WAIT(MAX_WAIT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .pe_req  (pe_req),
        .cpu_gnt (cpu_gnt),
        .pe_gnt  (pe_gnt)
    );

    assign cpu_waitreq = cpu_req && !cpu_gnt;
    assign pe_waitreq  = pe_req && !pe_gnt;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic cpu_hit;
            assign cpu_hit    = cpu_gnt && (cpu_bank == 1'(b));
            assign bk_wr[b]   = (pe_gnt && pe_write) || (cpu_hit && cpu_write);
            assign bk_rd[b]   = (pe_gnt && pe_read) || (cpu_hit && cpu_read);
            assign bk_addr[b] = pe_gnt ? pe_addr : cpu_row;
            assign bk_wd[b]   = pe_gnt ? pe_wdata[WORD_W*b +: WORD_W] : cpu_wdata;
            assign bk_be[b]   = pe_gnt ? pe_be[LANE_N*b +: LANE_N] : cpu_be;

            dbm_bank #(.AW(BANK_AW), .RD_LAT(RD_LAT)) u_bank (
                .clk   (clk),
                .wr_en (bk_wr[b]),
                .rd_en (bk_rd[b]),
                .addr  (bk_addr[b]),
                .wdata (bk_wd[b]),
                .be    (bk_be[b]),
                .rdata (bk_q[b])
            );
        end
    endgenerate

    dbm_rd_align #(.RD_LAT(RD_LAT)) u_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_rd_acc   (cpu_gnt && cpu_read),
        .cpu_bank     (cpu_bank),
        .pe_rd_acc    (pe_gnt && pe_read),
        .cpu_valid    (cpu_rvalid),
        .cpu_bank_out (rsel),
        .pe_valid     (pe_rvalid)
    );

    assign cpu_rdata = rsel ? bk_q[1] : bk_q[0];
    assign pe_rdata  = {bk_q[1], bk_q[0]};

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
    parameter int RD_LAT   = 1,
    parameter int MAX_WAIT = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_read,
    input logic cpu_write,
    input logic cpu_waitreq,
    input logic cpu_rvalid,
    input logic pe_read,
    input logic pe_write,
    input logic pe_waitreq,
    input logic pe_rvalid
);

    localparam int WW = $clog2(MAX_WAIT + 2) + 1;
    localparam int OW = $clog2(RD_LAT + 2) + 1;
    localparam logic [WW-1:0] WLIM = WW'(MAX_WAIT);
    localparam logic [OW-1:0] OLIM = OW'(RD_LAT);

    logic          cpu_req, pe_req;
    logic [WW-1:0] wcnt;
    logic [OW-1:0] cpu_owed, pe_owed;

    assign cpu_req = cpu_read || cpu_write;
    assign pe_req  = pe_read || pe_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            cpu_owed <= '0;
            pe_owed  <= '0;
        end else begin
            wcnt     <= (cpu_waitreq && wcnt <= WLIM) ? wcnt + WW'(1) : '0;
            cpu_owed <= cpu_owed + OW'(cpu_read && !cpu_waitreq) - OW'(cpu_rvalid);
            pe_owed  <= pe_owed + OW'(pe_read && !pe_waitreq) - OW'(pe_rvalid);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cpu_rvalid && !pe_rvalid));

    a_r3_pe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && pe_req && wcnt < WLIM) |-> (cpu_waitreq && !pe_waitreq));

    a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_waitreq && pe_req && !pe_waitreq));

    a_r4_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_waitreq |-> (wcnt < WLIM));

    a_r4_forced_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && pe_req && wcnt == WLIM) |-> (!cpu_waitreq && pe_waitreq));

    a_r5_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req || !pe_req) |-> !cpu_waitreq);

    a_r6_cpu_valid_owed: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (cpu_owed != '0));

    a_r6_cpu_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_owed <= OLIM);

    a_r10_pe_valid_owed: assert property (@(posedge clk) disable iff (!rst_n)
        pe_rvalid |-> (pe_owed != '0));

    a_r10_pe_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pe_owed <= OLIM);

endmodule

bind dualbank_mem dbm_checker #(.RD_LAT(RD_LAT), .MAX_WAIT(MAX_WAIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_read    (cpu_read),
    .cpu_write   (cpu_write),
    .cpu_waitreq (cpu_waitreq),
    .cpu_rvalid  (cpu_rvalid),
    .pe_read     (pe_read),
    .pe_write    (pe_write),
    .pe_waitreq  (pe_waitreq),
    .pe_rvalid   (pe_rvalid)
);

// File: tb/sim_dualbank_mem.sv
module sim_dualbank_mem;

    localparam int AW   = 4;
    localparam int LAT  = 2;
    localparam int MAXW = 3;
    localparam int NW   = 2 << AW;

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 5'd3, 32'h11223344, 4'hF, 32'h0},
        '{1'b0, 5'd3, 32'h0,        4'h0, 32'h11223344},
        '{1'b1, 5'd3, 32'hAABBCCDD, 4'h5, 32'h0},
        '{1'b0, 5'd3, 32'h0,        4'h0, 32'h11BB33DD},
        '{1'b1, 5'd4, 32'hCAFEF00D, 4'h8, 32'h0},
        '{1'b0, 5'd4, 32'h0,        4'h0, 32'hCA000000},
        '{1'b0, 5'd2, 32'h0,        4'h0, 32'h00000000},
        '{1'b1, 5'd2, 32'h1234BEEF, 4'h3, 32'h0},
        '{1'b0, 5'd2, 32'h0,        4'h0, 32'h0000BEEF},
        '{1'b0, 5'd3, 32'h0,        4'h0, 32'h11BB33DD}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW:0]   cpu_addr = '0;
    logic          cpu_read = 1'b0, cpu_write = 1'b0;
    logic [31:0]   cpu_wdata = '0;
    logic [3:0]    cpu_be = '0;
    logic          cpu_waitreq, cpu_rvalid;
    logic [31:0]   cpu_rdata;
    logic [AW-1:0] pe_addr = '0;
    logic          pe_read = 1'b0, pe_write = 1'b0;
    logic [63:0]   pe_wdata = '0;
    logic [7:0]    pe_be = '0;
    logic          pe_waitreq, pe_rvalid;
    logic [63:0]   pe_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int pe_mode  = 0;   // 0 directed/idle, 1 random, 2 back-to-back reads of row 0
    bit pe_acc_now = 1'b0;

    logic [31:0] m [NW];
    bit          ev_c [LAT];
    logic [31:0] ed_c [LAT];
    bit          ev_p [LAT];
    logic [63:0] ed_p [LAT];

    always #10 clk = ~clk;

    dualbank_mem #(.BANK_AW(AW), .RD_LAT(LAT), .MAX_WAIT(MAXW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_read(cpu_read), .cpu_write(cpu_write),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_waitreq(cpu_waitreq),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .pe_addr(pe_addr), .pe_read(pe_read), .pe_write(pe_write),
        .pe_wdata(pe_wdata), .pe_be(pe_be), .pe_waitreq(pe_waitreq),
        .pe_rdata(pe_rdata), .pe_rvalid(pe_rvalid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Reference model and valid/data alignment monitor (R6, R7, R10)
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                ev_c[i] = 1'b0;
                ev_p[i] = 1'b0;
            end
            pe_acc_now = 1'b0;
        end else begin
            bit ca, pa;
            if (cpu_rvalid || ev_c[LAT-1]) begin
                chk(cpu_rvalid == ev_c[LAT-1], "R6 cpu valid timing", 64'(cpu_rvalid), 64'(ev_c[LAT-1]));
                if (ev_c[LAT-1])
                    chk(cpu_rdata === ed_c[LAT-1], "R7 cpu read data", 64'(cpu_rdata), 64'(ed_c[LAT-1]));
            end
            if (pe_rvalid || ev_p[LAT-1]) begin
                chk(pe_rvalid == ev_p[LAT-1], "R10 pe valid timing", 64'(pe_rvalid), 64'(ev_p[LAT-1]));
                if (ev_p[LAT-1])
                    chk(pe_rdata === ed_p[LAT-1], "R10 pe read data", pe_rdata, ed_p[LAT-1]);
            end
            for (int i = LAT - 1; i > 0; i--) begin
                ev_c[i] = ev_c[i-1]; ed_c[i] = ed_c[i-1];
                ev_p[i] = ev_p[i-1]; ed_p[i] = ed_p[i-1];
            end
            ca = (cpu_read || cpu_write) && !cpu_waitreq;
            pa = (pe_read || pe_write) && !pe_waitreq;
            pe_acc_now = pa;
            ev_c[0] = ca && cpu_read;
            ed_c[0] = m[cpu_addr];
            ev_p[0] = pa && pe_read;
            ed_p[0] = {m[2*pe_addr+1], m[2*pe_addr]};
            if (ca && cpu_write)
                for (int k = 0; k < 4; k++)
                    if (cpu_be[k]) m[cpu_addr][8*k +: 8] = cpu_wdata[8*k +: 8];
            if (pa && pe_write)
                for (int k = 0; k < 8; k++)
                    if (pe_be[k]) m[2*pe_addr + k/4][8*(k%4) +: 8] = pe_wdata[8*k +: 8];
        end
    end

    // Background 64-bit traffic
    always @(posedge clk) begin
        #2;
        if (pe_mode == 2) begin
            pe_read = 1'b1; pe_write = 1'b0; pe_addr = '0;
        end else if (pe_mode == 1) begin
            if (!((pe_read || pe_write) && !pe_acc_now)) begin
                int r;
                logic [AW-1:0] row;
                r = $urandom % 4;
                row = AW'($urandom);
                if (row == AW'(2)) row = AW'(3);
                pe_addr  = row;
                pe_read  = (r == 1);
                pe_write = (r == 2);
                pe_wdata = {$urandom, $urandom};
                pe_be    = 8'($urandom);
            end
        end
    end

    task automatic cpu_op(input bit wr, input logic [4:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd,
                          output int waits, output int lat, output bit pe_blk);
        @(posedge clk); #2;
        cpu_read = !wr; cpu_write = wr; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        waits = 0;
        forever begin
            @(negedge clk);
            if (!cpu_waitreq) begin
                pe_blk = pe_waitreq;
                break;
            end
            waits++;
            if (waits > MAXW) chk(1'b0, "R4 wait bound", 64'(waits), 64'(MAXW));
            if (waits > 50) break;
        end
        @(posedge clk); #2;
        cpu_read = 1'b0; cpu_write = 1'b0;
        rd = '0; lat = 0;
        if (!wr) begin
            forever begin
                @(negedge clk);
                lat++;
                if (cpu_rvalid) begin
                    rd = cpu_rdata;
                    break;
                end
                if (lat > 20) break;
            end
            chk(lat == LAT, "R6 read latency", 64'(lat), 64'(LAT));
        end
    endtask

    task automatic pe_op(input bit wr, input logic [AW-1:0] a, input logic [63:0] d,
                         input logic [7:0] be, output logic [63:0] rd);
        @(posedge clk); #2;
        pe_read = !wr; pe_write = wr; pe_addr = a; pe_wdata = d; pe_be = be;
        forever begin
            @(negedge clk);
            if (!pe_waitreq) break;
        end
        @(posedge clk); #2;
        pe_read = 1'b0; pe_write = 1'b0;
        rd = '0;
        if (!wr) begin
            int n = 0;
            forever begin
                @(negedge clk);
                n++;
                if (pe_rvalid) begin
                    rd = pe_rdata;
                    break;
                end
                if (n > 20) break;
            end
            chk(n == LAT, "R10 pe read latency", 64'(n), 64'(LAT));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 64'(0), 64'(1));
        finish_sim();
    end

    initial begin
        logic [31:0] rd;
        logic [63:0] prd;
        int w, l;
        bit blk;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cpu_rvalid && !pe_rvalid, "R1 valids low in reset", 64'({cpu_rvalid, pe_rvalid}), 64'(0));
        chk(!cpu_waitreq && !pe_waitreq, "R1 waitreq low in reset", 64'({cpu_waitreq, pe_waitreq}), 64'(0));
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_rvalid && !pe_rvalid, "R1 valids low after reset", 64'({cpu_rvalid, pe_rvalid}), 64'(0));

        // Clear all rows through the 64-bit port
        for (int i = 0; i < (1 << AW); i++) pe_op(1'b1, AW'(i), 64'h0, 8'hFF, prd);

        // Table walk: processor writes and reads, 64-bit port idle (R5, R7, R8)
        for (int v = 0; v < 10; v++) begin
            cpu_op(VEC[v].wr, VEC[v].addr, VEC[v].data, VEC[v].be, rd, w, l, blk);
            chk(w == 0, "R5 no wait when uncontested", 64'(w), 64'(0));
            if (!VEC[v].wr) chk(rd === VEC[v].exp, "R8 byte-enable result", 64'(rd), 64'(VEC[v].exp));
        end

        // R2: bank mapping seen from both ports
        pe_op(1'b0, AW'(1), 64'h0, 8'h00, prd);
        chk(prd === 64'h11BB33DD_0000BEEF, "R2 row 1 = cpu words 3:2", prd, 64'h11BB33DD_0000BEEF);
        pe_op(1'b1, AW'(6), 64'h01234567_89ABCDEF, 8'hFF, prd);
        cpu_op(1'b0, 5'd12, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'h89ABCDEF, "R2 low half in bank 0", 64'(rd), 64'h89ABCDEF);
        cpu_op(1'b0, 5'd13, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'h01234567, "R2 high half in bank 1", 64'(rd), 64'h01234567);

        // R9: 64-bit byte enables split per bank
        pe_op(1'b1, AW'(6), 64'hFFFFFFFF_FFFFFFFF, 8'h0F, prd);
        pe_op(1'b1, AW'(6), 64'h00005555_00000000, 8'h30, prd);
        cpu_op(1'b0, 5'd12, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'hFFFFFFFF, "R9 enables 3:0 hit bank 0", 64'(rd), 64'hFFFFFFFF);
        cpu_op(1'b0, 5'd13, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'h01235555, "R9 enables 7:4 hit bank 1", 64'(rd), 64'h01235555);

        // R3/R4: continuous 64-bit requests starve the processor up to the limit
        pe_mode = 2;
        repeat (2) @(posedge clk);
        cpu_op(1'b0, 5'd3, 32'h0, 4'h0, rd, w, l, blk);
        chk(w > 0, "R3 pe wins conflict", 64'(w), 64'(MAXW));
        chk(w == MAXW, "R4 forced after limit", 64'(w), 64'(MAXW));
        chk(blk == 1'b1, "R4 pe held in forced cycle", 64'(blk), 64'(1));
        chk(rd === 32'h11BB33DD, "R7 read under contention", 64'(rd), 64'h11BB33DD);
        cpu_op(1'b1, 5'd4, 32'h0000_00AB, 4'h1, rd, w, l, blk);
        chk(w == MAXW, "R4 forced write", 64'(w), 64'(MAXW));
        pe_mode = 0;
        @(posedge clk); #2; pe_read = 1'b0; pe_write = 1'b0;
        cpu_op(1'b0, 5'd4, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'hCA0000AB, "R11 forced write applied once", 64'(rd), 64'hCA0000AB);

        // R11: read-increment-write loop under random 64-bit traffic
        cpu_op(1'b1, 5'd5, 32'd100, 4'hF, rd, w, l, blk);
        pe_mode = 1;
        for (int k = 0; k < 40; k++) begin
            cpu_op(1'b0, 5'd5, 32'h0, 4'h0, rd, w, l, blk);
            chk(rd === 32'(100 + k), "R11 loop value", 64'(rd), 64'(100 + k));
            cpu_op(1'b1, 5'd5, rd + 32'd1, 4'hF, rd, w, l, blk);
        end
        pe_mode = 0;
        @(posedge clk); #2; pe_read = 1'b0; pe_write = 1'b0;
        cpu_op(1'b0, 5'd5, 32'h0, 4'h0, rd, w, l, blk);
        chk(rd === 32'd140, "R11 final count", 64'(rd), 64'd140);
        repeat (LAT + 3) @(posedge clk);
        finish_sim();
    end

endmodule